// File: doc/BRIEF.md
# Per-Stage Retry and Vote Recovery Controller

This controller sits beside a pipeline that runs two redundant threads and compares their per-stage checksum registers. When a stage reports that the two threads disagree, the controller stalls the pipeline and rolls back only that stage. The stage then runs its instruction again from the checksum copy, which gives a third result. A vote between the third result and the two saved thread values decides what happens next. If the retry agrees with thread 2, thread 1 was the faulty one and the pipeline resumes unchanged. If the retry agrees only with thread 1, thread 2 was faulty, and the stage's pipeline register is reloaded from thread 1's checksum copy. If the retry agrees with neither, a restart from the last checkpoint is requested.

Neither thread is trusted in advance. A fault tally counts every detected disagreement. It clears after a set number of checkpoints pass with no fault. If a detection brings the tally to its limit, the controller goes straight to a fail-safe state, and only reset leaves that state. The controller does not contain the pipeline datapath. It only drives the stall, rollback, reload and restart controls.

Top module: `rbv_ctrl`

## Requirements
- R1: After reset, every output is low: stall, rollback, load, restore select, restore value, restart and fail-safe.
- R2: When the controller is idle and any bit of `mismatch_i` is high at a clock edge, the lowest-numbered flagged stage is selected. In the next cycle `stall_o` is high and `rollback_o` is one-hot on that stage (bit i means stage i) for exactly one cycle.
- R3: The cycle after rollback is the retry cycle. `retry_sig_i` is sampled at the end of that cycle. A vote cycle follows. `stall_o` stays high through both cycles, and `rollback_o` and `load_o` stay low.
- R4: If the retry value equals the saved thread-2 value (this check takes precedence), execution resumes: `stall_o` is low in the cycle after the vote, with no load and no restart.
- R5: If the retry value equals only the saved thread-1 value, there is one restore cycle after the vote. In that cycle `load_o` is one-hot on the stage, `restore_sel_o` holds the stage index, `restore_val_o` holds the saved thread-1 value and `stall_o` is high. `stall_o` is low in the following cycle.
- R6: If the retry value matches neither saved value, `restart_o` is high for one cycle after the vote, together with `stall_o`. The controller then returns to idle.
- R7: The thread values of the selected stage are captured in the detection cycle. While recovery is in progress, `mismatch_i` is ignored: it does not change the stage being recovered and it does not add to the fault tally.
- R8: Every detection adds one to the fault tally. If a detection brings the tally to FAULT_LIMIT (default 3), the next cycle is fail-safe, with no rollback.
- R9: The tally clears after CLEAN_CKPTS (default 2) `checkpoint_i` pulses that arrive while the controller is idle and no mismatch is flagged. Fewer clean checkpoints leave the tally unchanged.
- R10: Fail-safe holds `failsafe_o` and `stall_o` high and ignores all inputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mismatch_i | input | NSTAGE | Per-stage disagreement flags between the two threads |
| sig_t1_i | input | NSTAGE*CW | Thread-1 checksum registers; stage i occupies bits [i*CW +: CW] |
| sig_t2_i | input | NSTAGE*CW | Thread-2 checksum registers, same layout |
| retry_sig_i | input | CW | Result of the re-executed stage, valid in the retry cycle |
| checkpoint_i | input | 1 | Pulse marking a passed checkpoint |
| stall_o | output | 1 | Pipeline stall, high whenever the controller is not idle |
| rollback_o | output | NSTAGE | One-hot rollback of the stage to retry |
| load_o | output | NSTAGE | One-hot reload enable for the stage's pipeline register |
| restore_sel_o | output | SW | Index of the checksum register used as the reload source |
| restore_val_o | output | CW | Thread-1 checksum value to reload |
| restart_o | output | 1 | Request to restart both threads from a checkpoint |
| failsafe_o | output | 1 | Persistent-fault fail-safe flag |

## Verification
Every result follows the detection edge by a fixed number of cycles:
- rollback appears one cycle after detection;
- retry is the second cycle;
- the vote is the third cycle;
- the restore or restart cycle, or the resumed idle state, is the fourth.

In the restore and restart cases, idle is the fifth cycle. A fail-safe entry shows one cycle after detection. The bench drives inputs and samples outputs on the falling edge. Each check sits at the falling edge that follows the rising edge where that result becomes due, so each check looks at exactly one state. The thread inputs are changed after the detection edge, so a controller that fails to capture them yields the wrong vote or the wrong restore value.

// File: rtl/rbv_pkg.sv
package rbv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROLLBACK,
    ST_RETRY,
    ST_VOTE,
    ST_RESTORE,
    ST_RESTART,
    ST_FAILSAFE
  } rb_state_e;

  typedef enum logic [1:0] {
    VD_KEEP,
    VD_RESTORE,
    VD_RESTART
  } verdict_e;

  // Majority decision: agreement with thread 2 is checked first.
  function automatic verdict_e judge(input logic eq_t2, input logic eq_t1);
    if (eq_t2)      return VD_KEEP;
    else if (eq_t1) return VD_RESTORE;
    else            return VD_RESTART;
  endfunction

  // True when one more fault reaches the limit.
  function automatic logic at_limit(input int cnt, input int limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/rbv_pick.sv
module rbv_pick #(
  parameter int NSTAGE = 4,
  parameter int CW     = 8,
  parameter int SW     = 2
) (
  input  logic [NSTAGE-1:0]    mismatch_i,
  input  logic [NSTAGE*CW-1:0] sig_t1_i,
  input  logic [NSTAGE*CW-1:0] sig_t2_i,
  output logic [SW-1:0]        idx_o,
  output logic [CW-1:0]        t1_o,
  output logic [CW-1:0]        t2_o
);

  // Lowest flagged stage wins.
  always_comb begin
    idx_o = '0;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      if (mismatch_i[i]) idx_o = SW'(i);
    end
  end

  always_comb begin
    t1_o = sig_t1_i[int'(idx_o)*CW +: CW];
    t2_o = sig_t2_i[int'(idx_o)*CW +: CW];
  end

endmodule

// File: rtl/rbv_tally.sv
module rbv_tally #(
  parameter int FAULT_LIMIT = 3,
  parameter int CLEAN_CKPTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic detect_i,
  input  logic ckpt_ok_i,
  output logic limit_o
);
  import rbv_pkg::*;

  localparam int FW = $clog2(FAULT_LIMIT + 1);
  localparam int KW = $clog2(CLEAN_CKPTS + 1);

  logic [FW-1:0] fault_q;
  logic [KW-1:0] clean_q;

  assign limit_o = detect_i && at_limit(int'(fault_q), FAULT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      clean_q <= '0;
    end else if (detect_i) begin
      clean_q <= '0;
      if (int'(fault_q) < FAULT_LIMIT) fault_q <= fault_q + 1'b1;
    end else if (ckpt_ok_i) begin
      if (int'(clean_q) >= CLEAN_CKPTS - 1) begin
        clean_q <= '0;
        fault_q <= '0;
      end else begin
        clean_q <= clean_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rbv_fsm.sv
module rbv_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               detect_i,
  input  logic               limit_i,
  input  rbv_pkg::verdict_e  verdict_i,
  output rbv_pkg::rb_state_e state_o
);
  import rbv_pkg::*;

  rb_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      ST_IDLE:     if (detect_i) nxt = limit_i ? ST_FAILSAFE : ST_ROLLBACK;
      ST_ROLLBACK: nxt = ST_RETRY;
      ST_RETRY:    nxt = ST_VOTE;
      ST_VOTE: begin
        case (verdict_i)
          VD_RESTORE: nxt = ST_RESTORE;
          VD_RESTART: nxt = ST_RESTART;
          default:    nxt = ST_IDLE;
        endcase
      end
      ST_RESTORE:  nxt = ST_IDLE;
      ST_RESTART:  nxt = ST_IDLE;
      ST_FAILSAFE: nxt = ST_FAILSAFE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_IDLE;
    else        state_o <= nxt;
  end

endmodule

// File: rtl/rbv_ctrl.sv
module rbv_ctrl #(
  parameter int NSTAGE      = 4,
  parameter int CW          = 8,
  parameter int FAULT_LIMIT = 3,
  parameter int CLEAN_CKPTS = 2,
  localparam int SW         = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTAGE-1:0]    mismatch_i,
  input  logic [NSTAGE*CW-1:0] sig_t1_i,
  input  logic [NSTAGE*CW-1:0] sig_t2_i,
  input  logic [CW-1:0]        retry_sig_i,
  input  logic                 checkpoint_i,
  output logic                 stall_o,
  output logic [NSTAGE-1:0]    rollback_o,
  output logic [NSTAGE-1:0]    load_o,
  output logic [SW-1:0]        restore_sel_o,
  output logic [CW-1:0]        restore_val_o,
  output logic                 restart_o,
  output logic                 failsafe_o
);
  import rbv_pkg::*;

  rb_state_e     state;
  verdict_e      verdict;
  logic          detect_evt;   // fault accepted this cycle
  logic          ckpt_ok;      // clean checkpoint this cycle
  logic          limit_evt;    // accepted fault reaches the limit
  logic [SW-1:0] pick_idx;
  logic [CW-1:0] pick_t1, pick_t2;
  logic [SW-1:0] stage_q;
  logic [CW-1:0] t1_q, t2_q, rty_q;
  logic [NSTAGE-1:0] stage_mask;

  assign detect_evt = (state == ST_IDLE) && (mismatch_i != '0);
  assign ckpt_ok    = (state == ST_IDLE) && checkpoint_i && (mismatch_i == '0);
  assign verdict    = judge(rty_q == t2_q, rty_q == t1_q);
  assign stage_mask = NSTAGE'(1) << stage_q;

  rbv_pick #(.NSTAGE(NSTAGE), .CW(CW), .SW(SW)) u_pick (
    .mismatch_i (mismatch_i),
    .sig_t1_i   (sig_t1_i),
    .sig_t2_i   (sig_t2_i),
    .idx_o      (pick_idx),
    .t1_o       (pick_t1),
    .t2_o       (pick_t2)
  );

  rbv_tally #(.FAULT_LIMIT(FAULT_LIMIT), .CLEAN_CKPTS(CLEAN_CKPTS)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .detect_i  (detect_evt),
    .ckpt_ok_i (ckpt_ok),
    .limit_o   (limit_evt)
  );

  rbv_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .detect_i  (detect_evt),
    .limit_i   (limit_evt),
    .verdict_i (verdict),
    .state_o   (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      rty_q   <= '0;
    end else begin
      if (detect_evt) begin
        stage_q <= pick_idx;
        t1_q    <= pick_t1;
        t2_q    <= pick_t2;
      end
      if (state == ST_RETRY) rty_q <= retry_sig_i;
    end
  end

  assign stall_o       = (state != ST_IDLE);
  assign rollback_o    = (state == ST_ROLLBACK) ? stage_mask : '0;
  assign load_o        = (state == ST_RESTORE)  ? stage_mask : '0;
  assign restore_sel_o = (state == ST_RESTORE)  ? stage_q    : '0;
  assign restore_val_o = (state == ST_RESTORE)  ? t1_q       : '0;
  assign restart_o     = (state == ST_RESTART);
  assign failsafe_o    = (state == ST_FAILSAFE);

endmodule

// File: rtl/rbv_ctrl_chk.sv
module rbv_ctrl_chk #(
  parameter int NSTAGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSTAGE-1:0] mismatch_i,
  input logic              stall_o,
  input logic [NSTAGE-1:0] rollback_o,
  input logic [NSTAGE-1:0] load_o,
  input logic              restart_o,
  input logic              failsafe_o
);

  a_r2_rollback_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rollback_o));

  a_r5_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  a_r2_detect_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && mismatch_i != '0) |=> stall_o);

  a_r3_retry_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_o != '0) |=> (rollback_o == '0 && load_o == '0 && stall_o));

  a_r5_restore_single: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o != '0) |=> (load_o == '0 && !stall_o));

  a_r6_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (!restart_o && !stall_o));

  a_r10_failsafe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_o |=> (failsafe_o && stall_o));

  a_r8_failsafe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_o |-> (rollback_o == '0 && load_o == '0 && !restart_o));

endmodule

bind rbv_ctrl rbv_ctrl_chk #(.NSTAGE(NSTAGE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mismatch_i (mismatch_i),
  .stall_o    (stall_o),
  .rollback_o (rollback_o),
  .load_o     (load_o),
  .restart_o  (restart_o),
  .failsafe_o (failsafe_o)
);

// File: tb/rbv_ctrl_tb.sv
`timescale 1ns/1ps
module rbv_ctrl_tb;
  localparam int NS = 4;
  localparam int CW = 8;
  localparam int SW = 2;
  localparam int NV = 7;

  // {mismatch[29:26], t1[25:18], t2[17:10], retry[9:2], outcome[1:0]}
  // outcome: 0 resume, 1 restore, 2 restart
  localparam logic [29:0] VEC [NV] = '{
    {4'b0001, 8'h11, 8'h22, 8'h22, 2'd0},
    {4'b0100, 8'h33, 8'h44, 8'h33, 2'd1},
    {4'b1010, 8'h55, 8'h66, 8'h77, 2'd2},
    {4'b1000, 8'h99, 8'hAA, 8'hAA, 2'd0},
    {4'b1100, 8'hC3, 8'h3C, 8'hC3, 2'd1},
    {4'b0110, 8'h0F, 8'hF0, 8'hF1, 2'd2},
    {4'b1111, 8'h81, 8'h18, 8'h81, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    mismatch_i = '0;
  logic [NS*CW-1:0] sig_t1_i = '0;
  logic [NS*CW-1:0] sig_t2_i = '0;
  logic [CW-1:0]    retry_sig_i = '0;
  logic             checkpoint_i = 1'b0;
  logic             stall_o;
  logic [NS-1:0]    rollback_o;
  logic [NS-1:0]    load_o;
  logic [SW-1:0]    restore_sel_o;
  logic [CW-1:0]    restore_val_o;
  logic             restart_o;
  logic             failsafe_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rbv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mismatch_i(mismatch_i),
    .sig_t1_i(sig_t1_i), .sig_t2_i(sig_t2_i), .retry_sig_i(retry_sig_i),
    .checkpoint_i(checkpoint_i), .stall_o(stall_o), .rollback_o(rollback_o),
    .load_o(load_o), .restore_sel_o(restore_sel_o), .restore_val_o(restore_val_o),
    .restart_o(restart_o), .failsafe_o(failsafe_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int low_idx(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic set_sigs(input int stage, input logic [CW-1:0] a, input logic [CW-1:0] b);
    for (int s = 0; s < NS; s++) begin
      sig_t1_i[s*CW +: CW] = (s == stage) ? a : (8'hE7 ^ CW'(s));
      sig_t2_i[s*CW +: CW] = (s == stage) ? b : (8'h7E ^ CW'(s));
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    mismatch_i = '0;
    checkpoint_i = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic ckpts(input int n);
    for (int k = 0; k < n; k++) begin
      checkpoint_i = 1'b1;
      step();
    end
    checkpoint_i = 1'b0;
  endtask

  // Full resume-type fault, no checks; leaves controller idle.
  task automatic fault_quick(input logic [NS-1:0] m);
    set_sigs(low_idx(m), 8'h21, 8'h12);
    retry_sig_i = 8'h12;
    mismatch_i = m;
    step();
    mismatch_i = '0;
    for (int k = 0; k < 4; k++) step();
  endtask

  task automatic run_vec(input logic [29:0] v);
    logic [NS-1:0] m;
    logic [CW-1:0] a, b, r;
    int oc, st;
    m = v[29:26]; a = v[25:18]; b = v[17:10]; r = v[9:2]; oc = int'(v[1:0]);
    st = low_idx(m);
    set_sigs(st, a, b);
    retry_sig_i = r;
    mismatch_i = m;
    step();                                  // after detection edge: ROLLBACK
    mismatch_i = '0;
    set_sigs(st, 8'h00, 8'hFF);              // captured values must not follow inputs
    check("R2 stall", 32'(stall_o), 32'd1);
    check("R2 rollback lowest stage", 32'(rollback_o), 32'(1 << st));
    step();                                  // RETRY
    check("R3 retry no rollback", 32'(rollback_o), 32'd0);
    check("R3 retry stall", 32'(stall_o), 32'd1);
    step();                                  // VOTE
    check("R3 vote stall", 32'(stall_o), 32'd1);
    check("R3 vote no load", 32'(load_o), 32'd0);
    step();                                  // outcome
    if (oc == 0) begin
      check("R4 resume stall low", 32'(stall_o), 32'd0);
      check("R4 resume no load/restart", 32'({load_o, restart_o}), 32'd0);
    end else if (oc == 1) begin
      check("R5 load onehot", 32'(load_o), 32'(1 << st));
      check("R5 restore select", 32'(restore_sel_o), 32'(st));
      check("R5 restore value", 32'(restore_val_o), 32'(a));
      check("R5 restore stall", 32'(stall_o), 32'd1);
      step();
      check("R5 idle after restore", 32'({stall_o, load_o}), 32'd0);
    end else begin
      check("R6 restart", 32'(restart_o), 32'd1);
      check("R6 restart stall", 32'(stall_o), 32'd1);
      step();
      check("R6 idle after restart", 32'({stall_o, restart_o}), 32'd0);
    end
  endtask

  initial begin
    #(4 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    // R1: reset state
    check("R1 outputs at reset",
          32'({stall_o, rollback_o, load_o, restore_sel_o, restore_val_o, restart_o, failsafe_o}),
          32'd0);
    rst_n = 1'b1;
    step();

    // Table of vectors, tally cleared between them (R2..R6)
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
      ckpts(2);
    end

    // R7: mismatch ignored during recovery, not counted
    do_reset();
    set_sigs(0, 8'h11, 8'h22);
    retry_sig_i = 8'h22;
    mismatch_i = 4'b0001;
    step();
    mismatch_i = 4'b1000;
    set_sigs(3, 8'h22, 8'h11);
    check("R7 rollback stays on captured stage", 32'(rollback_o), 32'b0001);
    step();
    check("R7 no new rollback", 32'(rollback_o), 32'd0);
    step();
    mismatch_i = '0;
    step();
    check("R7 resume with captured values", 32'(stall_o), 32'd0);
    fault_quick(4'b0010);
    check("R7 ignored flags not counted", 32'(failsafe_o), 32'd0);

    // R8: limit reached on third detection
    do_reset();
    fault_quick(4'b0001);
    fault_quick(4'b0100);
    check("R8 two faults no failsafe", 32'(failsafe_o), 32'd0);
    mismatch_i = 4'b0010;
    step();
    mismatch_i = '0;
    check("R8 failsafe on limit", 32'(failsafe_o), 32'd1);
    check("R8 no rollback on limit", 32'(rollback_o), 32'd0);

    // R10: sticky until reset
    for (int k = 0; k < 4; k++) begin
      mismatch_i = 4'(k + 1);
      checkpoint_i = 1'b1;
      step();
      check("R10 failsafe held", 32'({failsafe_o, stall_o, rollback_o, load_o}), 32'h300);
    end
    mismatch_i = '0;
    checkpoint_i = 1'b0;
    do_reset();
    check("R10 reset leaves failsafe", 32'({failsafe_o, stall_o}), 32'd0);

    // R9: too few clean checkpoints keep the tally
    fault_quick(4'b0001);
    fault_quick(4'b0001);
    ckpts(1);
    mismatch_i = 4'b0001;
    step();
    mismatch_i = '0;
    check("R9 one checkpoint does not clear", 32'(failsafe_o), 32'd1);

    // R9: enough clean checkpoints clear the tally
    do_reset();
    fault_quick(4'b0001);
    fault_quick(4'b0001);
    ckpts(2);
    fault_quick(4'b0100);
    fault_quick(4'b0100);
    check("R9 cleared tally allows two more", 32'(failsafe_o), 32'd0);
    mismatch_i = 4'b0100;
    step();
    mismatch_i = '0;
    check("R9 third after clear hits limit", 32'(failsafe_o), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule